// File: doc/BRIEF.md
# SPI Register and Status Front End

This block is the bus-facing register file of an SPI peripheral. It holds five word-aligned registers: a read-only status byte, a read-only receive byte, a write-only transmit byte, a read/write clock divider and a 16-bit read/write control word. The serial shifter, clock generator and pin timing live in a separate engine, which talks to this block through a simple byte handshake. The engine takes the next transmit byte with a one-cycle load strobe, delivers each received byte with a one-cycle valid strobe, and reports through a busy level whether a transfer is still in flight.

The block keeps the status flags up to date from bus accesses and engine events. It applies the receive-overflow policy (keep the held byte or overwrite it) and the transmit-underflow policy (send zero or repeat the last byte). It selects which of two flags drives the single level interrupt, and it issues a one-cycle start request to the engine. Depending on the transfer mode, that request follows either a transmit write or a receive read. Bus reads return data one cycle after the read strobe.

Top module: `spi_csr_top`

## Requirements
- R1: After reset, status reads 0x00, receive reads 0x00, divider reads 0x1B, control reads 0x0000, the interrupt is low and no start request is issued.
- R2: Control bits 15:13 and bit 4 read as zero whatever is written, so writing 0xFFFF reads back 0x1FEF. The divider holds the last byte written to offset 0x0C and changes on no other access.
- R3: A received byte while the receive register is empty is stored, setting status bit 3 (full) and bit 4 (receive flag). A read of offset 0x04 returns the byte and clears bits 3, 4 and 5.
- R4: A byte arriving while bit 3 is set sets bit 5 (overflow) and bit 4. With control bit 8 = 0 the held byte is kept; with control bit 8 = 1 it is replaced by the new byte.
- R5: A write to offset 0x08 sets status bit 0 (busy) and clears bits 1 and 2. A load strobe while bit 0 is set presents that byte on `tx_byte` one cycle later and clears bit 0.
- R6: A load strobe while bit 0 is clear sets status bit 2 (underflow). `tx_byte` becomes 0x00 when control bit 7 = 1, or the last written byte when control bit 7 = 0.
- R7: Status bit 1 (transmit flag) sets one cycle after bit 0 is clear or bit 2 is set while enabled (control bit 0 = 1). It clears once control bit 0 = 0 and the engine is not busy, and stays set while the engine is still busy.
- R8: With control bit 0 = 1, a transmit write (control bit 6 = 1) or a receive read (control bit 6 = 0) raises `xfer_start` for exactly one cycle after the access. With control bit 0 = 0, no access raises it.
- R9: `irq` equals control bit 0 ANDed with status bit 1 when control bit 6 = 1, or with status bit 4 when control bit 6 = 0, registered one cycle behind the flags.
- R10: Writes to offsets 0x00 and 0x04 change nothing. A read of the write-only offset 0x08 returns zero. Status bits 7:6 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after the read strobe |
| eng_load | input | 1 | Engine takes the next transmit byte |
| eng_rx_valid | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_busy | input | 1 | Engine has a transfer in flight |
| tx_byte | output | 8 | Byte handed to the engine at the last load |
| xfer_start | output | 1 | One-cycle transfer start request |
| cfg_ctrl | output | 16 | Control word for the engine |
| cfg_div | output | 8 | Clock divider for the engine |
| irq | output | 1 | Level interrupt |

## Verification
Receive traffic covers three cases: a single byte, two bytes without a read in between with overwrite off, and two bytes with overwrite on. Comparing the byte that is read back separates the keep policy from the replace policy. On the transmit side, a load after a write is compared with a load on an empty register under each fill policy, which separates repeat-last from zero-fill. Both trigger modes are run with the block enabled and disabled, so a start request tied to the wrong access or leaking through while disabled shows up. The interrupt is checked with the other mode's flag set, so that a wrong source selection is caught.

// File: rtl/spi_csr_pkg.sv
package spi_csr_pkg;
  localparam int ADDR_W = 5;
  localparam int BYTE_W = 8;
  localparam int CTRL_W = 16;

  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_RX   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_TX   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_DIV  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h10;

  localparam logic [CTRL_W-1:0] CTRL_WMASK = 16'h1FEF;

  localparam int CB_EN    = 0;
  localparam int CB_TXMOD = 6;
  localparam int CB_ZFILL = 7;
  localparam int CB_OVWR  = 8;
endpackage

// File: rtl/spi_csr_cfg.sv
module spi_csr_cfg #(
  parameter int CTRL_W = 16,
  parameter int DIV_W = 8,
  parameter logic [DIV_W-1:0] DIV_RST = 8'h1B,
  parameter logic [CTRL_W-1:0] WMASK = 16'h1FEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_div,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [DIV_W-1:0]  div_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      div_q  <= DIV_RST;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata & WMASK;
      if (wr_div)  div_q  <= wdata[DIV_W-1:0];
    end
  end

  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_div |=> $stable(div_q)); // R2
endmodule

// File: rtl/spi_csr_rx.sv
module spi_csr_rx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_rx,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              ovwr_en,
  output logic [BYTE_W-1:0] rx_q,
  output logic              full_q,
  output logic              ovf_q
);
  logic held;
  assign held = full_q && !rd_rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q   <= '0;
      full_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (rx_valid) begin
        full_q <= 1'b1;
        ovf_q  <= held;
        if (!held || ovwr_en) rx_q <= rx_data;
      end else if (rd_rx) begin
        full_q <= 1'b0;
        ovf_q  <= 1'b0;
      end
    end
  end

  AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_rx && !rx_valid) |=> (!full_q && !ovf_q)); // R3
  AST_OVF_IMPLIES_FULL: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> full_q); // R4
  AST_DISCARD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && full_q && !rd_rx && !ovwr_en) |=> $stable(rx_q)); // R4
endmodule

// File: rtl/spi_csr_tx.sv
module spi_csr_tx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_tx,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              load,
  input  logic              zero_fill,
  input  logic              en,
  input  logic              eng_busy,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              pend_q,
  output logic              ufl_q,
  output logic              txf_q
);
  logic [BYTE_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      tx_byte <= '0;
      pend_q  <= 1'b0;
      ufl_q   <= 1'b0;
      txf_q   <= 1'b0;
    end else begin
      if (wr_tx) begin
        hold_q <= wdata;
        pend_q <= 1'b1;
        ufl_q  <= 1'b0;
      end else if (load) begin
        if (pend_q) begin
          tx_byte <= hold_q;
          pend_q  <= 1'b0;
        end else begin
          tx_byte <= zero_fill ? '0 : hold_q;
          ufl_q   <= 1'b1;
        end
      end
      if (wr_tx)                 txf_q <= 1'b0;
      else if (!en && !eng_busy) txf_q <= 1'b0;
      else if (!pend_q || ufl_q) txf_q <= 1'b1;
    end
  end

  AST_TX_WRITE_ARMS: assert property (@(posedge clk) disable iff (rst)
    wr_tx |=> (pend_q && !ufl_q && !txf_q)); // R5
  AST_UNDERFLOW_SETS: assert property (@(posedge clk) disable iff (rst)
    (load && !wr_tx && !pend_q) |=> ufl_q); // R6
endmodule

// File: rtl/spi_csr_top.sv
module spi_csr_top
  import spi_csr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BYTE_W,
  parameter int CW = CTRL_W,
  parameter logic [BW-1:0] DIV_RESET = 8'h1B
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  input  logic          eng_load,
  input  logic          eng_rx_valid,
  input  logic [BW-1:0] eng_rx_data,
  input  logic          eng_busy,
  output logic [BW-1:0] tx_byte,
  output logic          xfer_start,
  output logic [CW-1:0] cfg_ctrl,
  output logic [BW-1:0] cfg_div,
  output logic          irq
);
  localparam int STAT_PAD = CW - 6;

  logic wr_ctrl, wr_div, wr_tx, rd_rx;
  logic [BW-1:0] rx_q;
  logic full_q, ovf_q, pend_q, ufl_q, txf_q, rxf;
  logic en, txmode;

  assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_div  = bus_wr && (bus_addr == OFS_DIV);
  assign wr_tx   = bus_wr && (bus_addr == OFS_TX);
  assign rd_rx   = bus_rd && (bus_addr == OFS_RX);

  spi_csr_cfg #(.CTRL_W(CW), .DIV_W(BW), .DIV_RST(DIV_RESET), .WMASK(CTRL_WMASK)) u_cfg (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_div(wr_div),
    .wdata(bus_wdata), .ctrl_q(cfg_ctrl), .div_q(cfg_div)
  );

  assign en     = cfg_ctrl[CB_EN];
  assign txmode = cfg_ctrl[CB_TXMOD];

  spi_csr_rx #(.BYTE_W(BW)) u_rx (
    .clk(clk), .rst(rst), .rd_rx(rd_rx), .rx_valid(eng_rx_valid),
    .rx_data(eng_rx_data), .ovwr_en(cfg_ctrl[CB_OVWR]),
    .rx_q(rx_q), .full_q(full_q), .ovf_q(ovf_q)
  );

  spi_csr_tx #(.BYTE_W(BW)) u_tx (
    .clk(clk), .rst(rst), .wr_tx(wr_tx), .wdata(bus_wdata[BW-1:0]),
    .load(eng_load), .zero_fill(cfg_ctrl[CB_ZFILL]), .en(en),
    .eng_busy(eng_busy), .tx_byte(tx_byte), .pend_q(pend_q),
    .ufl_q(ufl_q), .txf_q(txf_q)
  );

  assign rxf = full_q || ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      xfer_start <= 1'b0;
      irq        <= 1'b0;
    end else begin
      xfer_start <= en && (txmode ? wr_tx : rd_rx);
      irq        <= en && (txmode ? txf_q : rxf);
      if (bus_rd) begin
        case (bus_addr)
          OFS_STAT: bus_rdata <= {{STAT_PAD{1'b0}}, ovf_q, rxf, full_q, ufl_q, txf_q, pend_q};
          OFS_RX:   bus_rdata <= {{(CW-BW){1'b0}}, rx_q};
          OFS_DIV:  bus_rdata <= {{(CW-BW){1'b0}}, cfg_div};
          OFS_CTRL: bus_rdata <= cfg_ctrl;
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end

  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    xfer_start |-> $past(en)); // R8
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(en)); // R9
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (en && txmode && !txf_q) |=> !irq); // R9
endmodule

// File: tb/tb_spi_csr_top.sv
module tb_spi_csr_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic eng_load = 1'b0, eng_rx_valid = 1'b0, eng_busy = 1'b0;
  logic [7:0] eng_rx_data = '0;
  logic [7:0] tx_byte;
  logic xfer_start, irq;
  logic [15:0] cfg_ctrl;
  logic [7:0] cfg_div;

  int checks = 0;
  int fails = 0;
  logic start_seen;
  logic [15:0] rd_val;

  always #5 clk = ~clk;

  spi_csr_top dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_load(eng_load),
    .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data), .eng_busy(eng_busy),
    .tx_byte(tx_byte), .xfer_start(xfer_start), .cfg_ctrl(cfg_ctrl),
    .cfg_div(cfg_div), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
    start_seen = xfer_start;
  endtask

  task automatic bus_read(input logic [4:0] a);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    rd_val = bus_rdata;
    start_seen = xfer_start;
  endtask

  task automatic rx_byte(input logic [7:0] d);
    eng_rx_data = d; eng_rx_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    eng_rx_valid = 1'b0;
  endtask

  task automatic load_pulse();
    eng_load = 1'b1;
    @(posedge clk); @(negedge clk);
    eng_load = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 irq", {15'b0, irq}, 16'h0);
    check("R1 start", {15'b0, xfer_start}, 16'h0);
    bus_read(5'h00); check("R1 status", rd_val, 16'h0000);
    bus_read(5'h04); check("R1 rx", rd_val, 16'h0000);
    check("R1 no start on rx read while disabled", {15'b0, start_seen}, 16'h0);
    bus_read(5'h0C); check("R1 div", rd_val, 16'h001B);
    bus_read(5'h10); check("R1 ctrl", rd_val, 16'h0000);
  endtask

  task automatic t_regs();
    bus_write(5'h00, 16'hFFFF);
    bus_write(5'h04, 16'hFFFF);
    idle(2);
    bus_read(5'h00); check("R10 status write ignored", rd_val, 16'h0000);
    bus_read(5'h04); check("R10 rx write ignored", rd_val, 16'h0000);
    bus_write(5'h0C, 16'h005A);
    bus_write(5'h10, 16'h0000);
    bus_read(5'h0C); check("R2 div write", rd_val, 16'h005A);
    bus_write(5'h10, 16'hFFFF);
    bus_read(5'h10); check("R2 ctrl reserved zero", rd_val, 16'h1FEF);
    bus_read(5'h0C); check("R2 div unchanged by ctrl write", rd_val, 16'h005A);
    bus_read(5'h08); check("R10 tx reads zero", rd_val, 16'h0000);
    bus_write(5'h10, 16'h0000);
    idle(3);
  endtask

  task automatic t_rx();
    bus_write(5'h10, 16'h0001);
    idle(2);
    rx_byte(8'hA5);
    idle(2);
    bus_read(5'h00); check("R3 full and flag", rd_val, 16'h001A);
    check("R9 irq follows receive flag", {15'b0, irq}, 16'h1);
    bus_read(5'h04); check("R3 rx data", rd_val, 16'h00A5);
    check("R8 start on rx read", {15'b0, start_seen}, 16'h1);
    idle(1);
    check("R8 start one cycle", {15'b0, xfer_start}, 16'h0);
    idle(1);
    bus_read(5'h00); check("R3 read clears", rd_val, 16'h0002);
    check("R9 irq drops", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_ovf();
    rx_byte(8'hA1); rx_byte(8'hB2);
    idle(1);
    bus_read(5'h00); check("R4 overflow status", rd_val, 16'h003A);
    bus_read(5'h04); check("R4 discard keeps first", rd_val, 16'h00A1);
    bus_read(5'h00); check("R4 overflow cleared", rd_val, 16'h0002);
    bus_write(5'h10, 16'h0101);
    rx_byte(8'hC3); rx_byte(8'hD4);
    bus_read(5'h04); check("R4 overwrite keeps new", rd_val, 16'h00D4);
  endtask

  task automatic t_tx();
    bus_write(5'h10, 16'h0041);
    idle(2);
    bus_write(5'h08, 16'h003C);
    check("R8 start on tx write", {15'b0, start_seen}, 16'h1);
    rx_byte(8'h11);
    idle(1);
    bus_read(5'h00); check("R5 busy set flag clear", rd_val, 16'h0019);
    check("R9 tx mode ignores receive flag", {15'b0, irq}, 16'h0);
    bus_read(5'h04);
    check("R8 no start on rx read in tx mode", {15'b0, start_seen}, 16'h0);
    load_pulse();
    check("R5 tx byte out", {8'h0, tx_byte}, 16'h003C);
    idle(2);
    bus_read(5'h00); check("R5 busy cleared", rd_val, 16'h0002);
    check("R9 irq from tx flag", {15'b0, irq}, 16'h1);
  endtask

  task automatic t_ufl();
    load_pulse();
    check("R6 resend previous", {8'h0, tx_byte}, 16'h003C);
    idle(1);
    bus_read(5'h00); check("R6 underflow flag", rd_val, 16'h0006);
    bus_write(5'h10, 16'h00C1);
    load_pulse();
    check("R6 zero fill", {8'h0, tx_byte}, 16'h0000);
    bus_write(5'h08, 16'h0077);
    bus_read(5'h00); check("R5 write clears underflow", rd_val, 16'h0001);
  endtask

  task automatic t_disable();
    load_pulse();
    idle(2);
    bus_read(5'h00); check("R7 flag set when empty", rd_val, 16'h0002);
    eng_busy = 1'b1;
    bus_write(5'h10, 16'h0040);
    idle(2);
    bus_read(5'h00); check("R7 held while engine busy", rd_val, 16'h0002);
    check("R9 irq off when disabled", {15'b0, irq}, 16'h0);
    eng_busy = 1'b0;
    idle(2);
    bus_read(5'h00); check("R7 cleared after finish", rd_val, 16'h0000);
    bus_write(5'h08, 16'h0055);
    check("R8 no start when disabled", {15'b0, start_seen}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_rx();
    t_ovf();
    t_tx();
    t_ufl();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule